// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers interrupt requests that arrive as a (level, source) pair and keeps, for every priority level, a vector of pending sources plus one summary bit saying whether that level has anything pending. Requests are added through a post port and removed through a separate clear port. A clear-all strobe empties every level in a single cycle.

Each cycle the block merges two request groups into one priority number. The first group is a software request word, where level i maps to priority (i - lowest software level + 1). The second group is the per-level summary bits inside the external range, where level i maps to priority i. The highest candidate wins. An interrupt is taken only when that number is nonzero and strictly above the current priority level. When the evaluate strobe meets a taken interrupt, the winning priority and the mask of contributing levels are held. A later update strobe copies them to the summary and ID outputs.

A small two-state machine tracks the holding registers. In HS_EMPTY nothing is held. A capture (evaluate strobe while an interrupt is taken) moves it to HS_HELD. In HS_HELD an update without a capture returns it to HS_EMPTY. An update with a capture stays in HS_HELD, holding the new values. Any other input leaves the state unchanged.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post with level below NUM_LVL and source below SRC_W sets that source bit and, from the next cycle, pend_sum bit [level] reads 1; source indices up to SRC_W-1 are usable.
- R2: A clear removes one source bit; pend_sum bit [level] drops to 0 only when no source of that level is left pending.
- R3: When post and clear name the same level and source in one cycle, the bit ends up set.
- R4: clr_all makes pend_sum all zero in the next cycle and overrides a post in the same cycle.
- R5: int_avail is 1 exactly when pend_sum is nonzero and pc_low equals 2'b00.
- R6: The priority is the highest candidate: software bit i in [SW_LO, SW_HI] gives i-SW_LO+1, and pend_sum bit i in [EXT_LO, EXT_HI] gives i. The mask has bit i set for every contributing level.
- R7: int_take is 1 only when the priority is nonzero, strictly greater than cur_ipl, and ast_req is 0.
- R8: eval_en with int_take captures priority and mask and sets hold_valid the next cycle. upd_en with hold_valid writes them to intid_out and isr_out and clears hold_valid, unless a capture happens in the same cycle.
- R9: ast_req=1 blocks int_take and sets err from the next cycle on.
- R10: A post or clear with level >= NUM_LVL or source >= SRC_W changes no pending state and sets err. err stays 1 until reset.
- R11: upd_en while hold_valid is 0 sets err and leaves isr_out and intid_out unchanged.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Post strobe |
| post_lvl | input | LVL_IW | Level for the post |
| post_src | input | SRC_IW | Source index for the post |
| clr_en | input | 1 | Clear strobe |
| clr_lvl | input | LVL_IW | Level for the clear |
| clr_src | input | SRC_IW | Source index for the clear |
| clr_all | input | 1 | Empty every level |
| sw_req | input | NUM_LVL | Software request word |
| cur_ipl | input | LVL_IW | Current priority level |
| pc_low | input | 2 | Two low program counter bits |
| ast_req | input | 1 | Unsupported trap request |
| eval_en | input | 1 | Evaluate strobe, captures when taken |
| upd_en | input | 1 | Update strobe, commits held values |
| int_avail | output | 1 | Something pending and PC aligned |
| int_take | output | 1 | Interrupt would be taken now |
| pend_sum | output | NUM_LVL | Per-level summary bits |
| hold_valid | output | 1 | Holding registers are full |
| isr_out | output | NUM_LVL | Committed summary mask |
| intid_out | output | LVL_IW | Committed priority |
| err | output | 1 | Sticky error |

## Verification
The bench builds the block with 32 levels of 64 sources, a software range of 2 to 9 and an external range of 16 to 29. With a software base above 1, a wrong offset changes the reported priority. The gap levels 10 to 15 and the top levels 30 and 31 can hold pending bits but never set a priority, so a scan over the wrong range shows up. Source 63 reaches the top of the full source width. Level indices up to 63 reach the out-of-range rejection path.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
    typedef enum logic [0:0] {
        HS_EMPTY = 1'b0,
        HS_HELD  = 1'b1
    } hold_st_e;
endpackage

// File: rtl/ilc_pend_bank.sv
module ilc_pend_bank #(
    parameter int NUM_LVL = 32,
    parameter int SRC_W   = 64,
    parameter int LVL_IW  = 6,
    parameter int SRC_IW  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_ok,
    input  logic [LVL_IW-1:0]  post_lvl,
    input  logic [SRC_IW-1:0]  post_src,
    input  logic               clr_ok,
    input  logic [LVL_IW-1:0]  clr_lvl,
    input  logic [SRC_IW-1:0]  clr_src,
    input  logic               clr_all,
    output logic [NUM_LVL-1:0] pend_sum
);
    localparam logic [SRC_W-1:0] ONE_HOT0 = {{(SRC_W-1){1'b0}}, 1'b1};

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [SRC_W-1:0] vec_q;
        logic [SRC_W-1:0] vec_d;
        logic [SRC_W-1:0] set_m;
        logic [SRC_W-1:0] kill_m;
        logic             set_hit;
        logic             kill_hit;
        logic             sum_q;

        always_comb begin
            set_hit  = post_ok && (post_lvl == LVL_IW'(l));
            kill_hit = clr_ok  && (clr_lvl  == LVL_IW'(l));
            set_m    = set_hit  ? (ONE_HOT0 << post_src) : '0;
            kill_m   = kill_hit ? (ONE_HOT0 << clr_src)  : '0;
            // set applied after kill: post beats clear on the same bit
            vec_d    = (vec_q & ~kill_m) | set_m;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q <= '0;
                sum_q <= 1'b0;
            end else if (clr_all) begin
                vec_q <= '0;
                sum_q <= 1'b0;
            end else begin
                vec_q <= vec_d;
                if (set_hit) begin
                    sum_q <= 1'b1;
                end else if (kill_hit && (vec_d == '0)) begin
                    sum_q <= 1'b0;
                end
            end
        end

        assign pend_sum[l] = sum_q;
    end
endmodule

// File: rtl/ilc_prio_eval.sv
module ilc_prio_eval #(
    parameter int NUM_LVL = 32,
    parameter int LVL_IW  = 6,
    parameter int SW_LO   = 1,
    parameter int SW_HI   = 15,
    parameter int EXT_LO  = 16,
    parameter int EXT_HI  = 31
) (
    input  logic [NUM_LVL-1:0] sw_req,
    input  logic [NUM_LVL-1:0] pend_sum,
    input  logic [LVL_IW-1:0]  cur_ipl,
    input  logic               ast_req,
    output logic [LVL_IW-1:0]  new_prio,
    output logic [NUM_LVL-1:0] new_mask,
    output logic               take
);
    always_comb begin
        new_prio = '0;
        new_mask = '0;
        // software group first, external group second; last hit wins
        for (int i = SW_LO; i <= SW_HI; i++) begin
            if (sw_req[i]) begin
                new_prio    = LVL_IW'(i - SW_LO + 1);
                new_mask[i] = 1'b1;
            end
        end
        for (int i = EXT_LO; i <= EXT_HI; i++) begin
            if (pend_sum[i]) begin
                new_prio    = LVL_IW'(i);
                new_mask[i] = 1'b1;
            end
        end
        take = (new_prio != '0) && (new_prio > cur_ipl) && !ast_req;
    end
endmodule

// File: rtl/ilc_hold_fsm.sv
module ilc_hold_fsm
    import ilc_pkg::*;
#(
    parameter int NUM_LVL = 32,
    parameter int LVL_IW  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic [LVL_IW-1:0]  cap_prio,
    input  logic [NUM_LVL-1:0] cap_mask,
    input  logic               upd,
    output logic               hold_valid,
    output logic               upd_err,
    output logic [NUM_LVL-1:0] isr_q,
    output logic [LVL_IW-1:0]  intid_q
);
    hold_st_e           state_q;
    hold_st_e           state_d;
    logic [LVL_IW-1:0]  hold_prio;
    logic [NUM_LVL-1:0] hold_mask;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_EMPTY: if (cap) state_d = HS_HELD;
            HS_HELD:  if (upd && !cap) state_d = HS_EMPTY;
            default:  state_d = HS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_prio <= '0;
            hold_mask <= '0;
            isr_q     <= '0;
            intid_q   <= '0;
        end else begin
            if (upd && (state_q == HS_HELD)) begin
                isr_q   <= hold_mask;
                intid_q <= hold_prio;
            end
            if (cap) begin
                hold_prio <= cap_prio;
                hold_mask <= cap_mask;
            end
        end
    end

    always_comb begin
        hold_valid = (state_q == HS_HELD);
        upd_err    = upd && (state_q == HS_EMPTY);
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
    parameter int NUM_LVL = 32,
    parameter int SRC_W   = 64,
    parameter int SW_LO   = 1,
    parameter int SW_HI   = 15,
    parameter int EXT_LO  = 16,
    parameter int EXT_HI  = 31,
    localparam int LVL_IW = $clog2(NUM_LVL) + 1,
    localparam int SRC_IW = $clog2(SRC_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_en,
    input  logic [LVL_IW-1:0]  post_lvl,
    input  logic [SRC_IW-1:0]  post_src,
    input  logic               clr_en,
    input  logic [LVL_IW-1:0]  clr_lvl,
    input  logic [SRC_IW-1:0]  clr_src,
    input  logic               clr_all,
    input  logic [NUM_LVL-1:0] sw_req,
    input  logic [LVL_IW-1:0]  cur_ipl,
    input  logic [1:0]         pc_low,
    input  logic               ast_req,
    input  logic               eval_en,
    input  logic               upd_en,
    output logic               int_avail,
    output logic               int_take,
    output logic [NUM_LVL-1:0] pend_sum,
    output logic               hold_valid,
    output logic [NUM_LVL-1:0] isr_out,
    output logic [LVL_IW-1:0]  intid_out,
    output logic               err
);
    logic               post_in_rng;
    logic               clr_in_rng;
    logic [LVL_IW-1:0]  new_prio;
    logic [NUM_LVL-1:0] new_mask;
    logic               upd_err;
    logic               err_q;

    always_comb begin
        post_in_rng = (post_lvl < LVL_IW'(NUM_LVL)) && (post_src < SRC_IW'(SRC_W));
        clr_in_rng  = (clr_lvl  < LVL_IW'(NUM_LVL)) && (clr_src  < SRC_IW'(SRC_W));
    end

    ilc_pend_bank #(
        .NUM_LVL (NUM_LVL),
        .SRC_W   (SRC_W),
        .LVL_IW  (LVL_IW),
        .SRC_IW  (SRC_IW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_ok  (post_en && post_in_rng),
        .post_lvl (post_lvl),
        .post_src (post_src),
        .clr_ok   (clr_en && clr_in_rng),
        .clr_lvl  (clr_lvl),
        .clr_src  (clr_src),
        .clr_all  (clr_all),
        .pend_sum (pend_sum)
    );

    ilc_prio_eval #(
        .NUM_LVL (NUM_LVL),
        .LVL_IW  (LVL_IW),
        .SW_LO   (SW_LO),
        .SW_HI   (SW_HI),
        .EXT_LO  (EXT_LO),
        .EXT_HI  (EXT_HI)
    ) u_eval (
        .sw_req   (sw_req),
        .pend_sum (pend_sum),
        .cur_ipl  (cur_ipl),
        .ast_req  (ast_req),
        .new_prio (new_prio),
        .new_mask (new_mask),
        .take     (int_take)
    );

    ilc_hold_fsm #(
        .NUM_LVL (NUM_LVL),
        .LVL_IW  (LVL_IW)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (eval_en && int_take),
        .cap_prio   (new_prio),
        .cap_mask   (new_mask),
        .upd        (upd_en),
        .hold_valid (hold_valid),
        .upd_err    (upd_err),
        .isr_q      (isr_out),
        .intid_q    (intid_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((post_en && !post_in_rng) || (clr_en && !clr_in_rng) ||
                     ast_req || upd_err) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        int_avail = (pend_sum != '0) && (pc_low == 2'b00);
        err       = err_q;
    end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NUM_LVL = 32,
    parameter int SRC_W   = 64,
    localparam int LVL_IW = $clog2(NUM_LVL) + 1,
    localparam int SRC_IW = $clog2(SRC_W) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_en,
    input logic [LVL_IW-1:0]  post_lvl,
    input logic [SRC_IW-1:0]  post_src,
    input logic               clr_all,
    input logic               ast_req,
    input logic               eval_en,
    input logic               upd_en,
    input logic               int_take,
    input logic [NUM_LVL-1:0] pend_sum,
    input logic               hold_valid,
    input logic [NUM_LVL-1:0] isr_out,
    input logic [LVL_IW-1:0]  intid_out,
    input logic               err
);
    // R1
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && !clr_all && post_lvl < LVL_IW'(NUM_LVL) && post_src < SRC_IW'(SRC_W))
        |=> pend_sum[$past(post_lvl[LVL_IW-2:0])]);
    // R4
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_sum == '0));
    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && int_take) |=> hold_valid);
    // R8
    commit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && hold_valid && !(eval_en && int_take)) |=> !hold_valid);
    // R9
    ast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ast_req |-> !int_take);
    // R9
    ast_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ast_req |=> err);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R11
    upd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !hold_valid) |=> (err && $stable(isr_out) && $stable(intid_out)));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_LVL(NUM_LVL), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;
    localparam int NL = 32, SW = 64, SWL = 2, SWH = 9, EXL = 16, EXH = 29;
    localparam int LIW = 6, SIW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic post_en, clr_en, clr_all, ast_req, eval_en, upd_en;
    logic [LIW-1:0] post_lvl, clr_lvl, cur_ipl;
    logic [SIW-1:0] post_src, clr_src;
    logic [NL-1:0] sw_req;
    logic [1:0] pc_low;
    logic int_avail, int_take, hold_valid, err;
    logic [NL-1:0] pend_sum, isr_out;
    logic [LIW-1:0] intid_out;

    int checks = 0, fails = 0;
    logic [SW-1:0] pm [NL];
    logic [NL-1:0] m_isr, h_mask;
    int m_id, h_prio;
    logic m_hv, m_err;

    always #4 clk = ~clk;

    irq_level_ctrl #(.NUM_LVL(NL), .SRC_W(SW), .SW_LO(SWL), .SW_HI(SWH),
                     .EXT_LO(EXL), .EXT_HI(EXH)) i_irq_level_ctrl (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] msum();
        logic [NL-1:0] s;
        for (int l = 0; l < NL; l++) s[l] = |pm[l];
        return s;
    endfunction

    function automatic void calc(input logic [NL-1:0] sw, input logic [NL-1:0] sm,
                                 output int p, output logic [NL-1:0] m);
        p = 0; m = '0;
        for (int i = SWL; i <= SWH; i++) if (sw[i]) begin p = i - SWL + 1; m[i] = 1'b1; end
        for (int i = EXL; i <= EXH; i++) if (sm[i]) begin p = i; m[i] = 1'b1; end
    endfunction

    task automatic idle();
        post_en = 0; clr_en = 0; clr_all = 0; ast_req = 0; eval_en = 0; upd_en = 0;
        post_lvl = '0; clr_lvl = '0; post_src = '0; clr_src = '0;
        sw_req = '0; cur_ipl = '0; pc_low = '0;
    endtask

    task automatic model_clear();
        for (int l = 0; l < NL; l++) pm[l] = '0;
        m_isr = '0; h_mask = '0; m_id = 0; h_prio = 0; m_hv = 0; m_err = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0; model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    // inputs already driven at a negedge; check combinational, advance, check registered
    task automatic step();
        int p; logic [NL-1:0] m; logic tk, pok, cok;
        #1;
        calc(sw_req, msum(), p, m);
        tk = (p != 0) && (p > int'(cur_ipl)) && !ast_req;
        chk("R5 int_avail", int_avail, (msum() != 0) && (pc_low == 2'b00));
        chk("R7 int_take", int_take, tk);
        pok = post_en && post_lvl < NL && post_src < SW;
        cok = clr_en && clr_lvl < NL && clr_src < SW;
        if ((post_en && !pok) || (clr_en && !cok) || ast_req) m_err = 1;
        if (upd_en) begin
            if (m_hv) begin m_isr = h_mask; m_id = h_prio; m_hv = 0; end
            else m_err = 1;
        end
        if (eval_en && tk) begin h_prio = p; h_mask = m; m_hv = 1; end
        if (clr_all) begin
            for (int l = 0; l < NL; l++) pm[l] = '0;
        end else begin
            if (cok) pm[clr_lvl][clr_src] = 1'b0;
            if (pok) pm[post_lvl][post_src] = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        chk("R1 pend_sum", pend_sum, msum());
        chk("R8 hold_valid", hold_valid, m_hv);
        chk("R8 isr_out", isr_out, m_isr);
        chk("R6 intid_out", intid_out, m_id);
        chk("R10 err", err, m_err);
        idle();
    endtask

    function automatic logic [SIW-1:0] rsrc();
        logic [SIW-1:0] s = SIW'($urandom_range(0, 3));
        return ($urandom_range(0, 1) == 1) ? SIW'(SW - 1) - s : s;
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h51c7));
        do_reset();
        // R12: reset state
        chk("R12 reset", {int_avail, int_take, hold_valid, err, pend_sum, isr_out, 6'(intid_out)},
            '0);

        // constrained random, no error sources
        for (int n = 0; n < 600; n++) begin
            post_en  = ($urandom_range(0, 2) != 0);
            post_lvl = LIW'($urandom_range(0, NL - 1));
            post_src = rsrc();
            clr_en   = ($urandom_range(0, 1) == 1);
            clr_lvl  = ($urandom_range(0, 1) == 1) ? post_lvl : LIW'($urandom_range(0, NL - 1));
            clr_src  = rsrc();
            clr_all  = ($urandom_range(0, 40) == 0);
            sw_req   = $urandom() & $urandom();
            cur_ipl  = LIW'($urandom_range(0, 31));
            pc_low   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            eval_en  = ($urandom_range(0, 1) == 1);
            upd_en   = m_hv && ($urandom_range(0, 2) == 0);
            step();
        end

        // R2: clear keeps the summary while another source remains
        clr_all = 1; step();
        post_en = 1; post_lvl = 5; post_src = 63; step();
        post_en = 1; post_lvl = 5; post_src = 0; step();
        clr_en = 1; clr_lvl = 5; clr_src = 0; step();
        chk("R2 level kept", pend_sum[5], 1'b1);
        clr_en = 1; clr_lvl = 5; clr_src = 63; step();
        chk("R2 level emptied", pend_sum[5], 1'b0);

        // R3: post beats clear on the same bit
        post_en = 1; post_lvl = 7; post_src = 10; clr_en = 1; clr_lvl = 7; clr_src = 10; step();
        chk("R3 post wins", pend_sum[7], 1'b1);

        // R4: clear-all beats a post
        clr_all = 1; post_en = 1; post_lvl = 8; post_src = 1; step();
        chk("R4 all zero", pend_sum, '0);

        // R5: misaligned PC hides a pending level
        post_en = 1; post_lvl = 12; post_src = 3; step();
        pc_low = 2'b10; #1; chk("R5 misaligned", int_avail, 1'b0);
        pc_low = 2'b00; #1; chk("R5 aligned", int_avail, 1'b1);
        step();

        // R6/R8: software offset, capture then commit
        sw_req = 32'h4; eval_en = 1; step();
        upd_en = 1; step();
        chk("R6 software offset", intid_out, 6'd1);
        chk("R8 mask", isr_out, 32'h4);

        // R7: equal level not taken, one below taken; gap level 12 gives nothing
        post_en = 1; post_lvl = 20; post_src = 0; step();
        cur_ipl = 20; #1; chk("R7 equal level", int_take, 1'b0);
        cur_ipl = 19; #1; chk("R7 lower level", int_take, 1'b1);
        sw_req = 32'h200; eval_en = 1; step();
        upd_en = 1; step();
        chk("R6 external wins", intid_out, 6'd20);
        chk("R6 merged mask", isr_out, 32'h0010_0200);

        // R10: out-of-range post ignored, sets err
        do_reset();
        post_en = 1; post_lvl = 40; post_src = 2; step();
        post_en = 1; post_lvl = 3; post_src = 64; step();
        chk("R10 ignored", pend_sum, '0);
        chk("R10 err set", err, 1'b1);
        step();
        chk("R10 sticky", err, 1'b1);

        // R11: update with nothing held
        do_reset();
        upd_en = 1; step();
        chk("R11 err", err, 1'b1);
        chk("R11 isr unchanged", isr_out, '0);

        // R9: trap request blocks and flags
        do_reset();
        post_en = 1; post_lvl = 25; post_src = 9; step();
        ast_req = 1; eval_en = 1; #1;
        chk("R9 blocked", int_take, 1'b0);
        step();
        chk("R9 err", err, 1'b1);
        chk("R9 nothing held", hold_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule